// File: doc/BRIEF.md
# Five-Channel Output-Compare Timer

This block holds a 16-bit up-counter and five compare channels. The counter advances by one on each cycle in which the `tick` clock enable is high. After 0xFFFF it returns to 0x0000. Each channel has its own 16-bit compare value. When the counter steps onto a channel's value, that channel's flag is set. This happens on every pass of the counter, not only the first one.

Software reaches the block through a byte-wide register bus. The bus gives access to the counter, the compare values, an enable (mask) register and a flag register. A flag stays set until software writes a one to its bit. A single interrupt line is asserted while any flag has its enable bit set. A channel whose enable bit is zero runs in polled mode: software reads its flag, but the flag never drives the interrupt.

Register map (byte addresses):
- 0x0 and 0x1: counter high byte and counter low byte.
- 0x2 to 0xB: compare channels 1 to 5, two bytes each. Each pair is the high byte at the even address, followed by the low byte.
- 0xC: mask register.
- 0xD: flag register.

Other addresses read as zero.

Top module: `ocu_timer`

## Requirements
- R1: The counter resets to 0. It rises by exactly one on each clock edge where `tick` is high, wraps from 0xFFFF to 0x0000, and holds its value while `tick` is low.
- R2: A read of address 0x0 returns the counter high byte and, on the same edge, captures the counter low byte. A read of address 0x1 returns the byte captured by the most recent high-byte read, even if the counter has moved since then.
- R3: A write to a compare high-byte address only stages that byte. The 16-bit compare value changes only when the matching low-byte address is written. At that point the value becomes the staged high byte joined with the new low byte. Readback returns the active compare value.
- R4: A channel's flag is set on the clock edge where a tick moves the counter onto that channel's compare value. This repeats on every wrap of the counter.
- R5: Writing the flag register clears each flag whose data bit is one. Flags whose data bit is zero are left unchanged. Nothing else clears a flag.
- R6: If a match and a write-one clear reach the same flag on the same edge, the flag is left set.
- R7: Mask bits do not affect how flags are set or cleared. With a channel's mask bit at zero, its flag still sets and `irq` stays low.
- R8: `irq` is registered. One clock after any flag bit and its mask bit are both one, `irq` is high. One clock after no such pair exists, `irq` is low.
- R9: In the mask and flag registers, bits 7, 6, 5, 4 and 3 belong to channels 1, 2, 3, 4 and 5. Bits 2 to 0 of the mask register are plain read/write storage. Bits 2 to 0 of the flag register have no set source and always read zero.
- R10: After reset, the mask and flag registers read 0x00, every compare value reads 0xFFFF, and `irq` is low.
- R11: Read data is registered. `bus_rdata` shows the addressed byte one clock after the read request and holds that value until the next read. Unmapped addresses return 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Counter clock enable |
| bus_sel | input | 1 | Register access request |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Byte address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| irq | output | 1 | Combined interrupt request |

## Verification
A miscounting counter is seen at once on a counter read, but only when `tick` is held low so the expected value is known. A wrong compare or staging register stays hidden until the counter reaches the intended value. The flag then sets at the wrong tick, or only after a full wrap of 65536 ticks, and a flag read right after the tick shows the error. A wrong flag or mask bit reaches `irq` one clock later. A wrong clear priority is seen only when a clear and a match fall on the same edge.

// File: rtl/ocu_pkg.sv
package ocu_pkg;
  localparam int CNT_W    = 16;
  localparam int BYTE_W   = 8;
  localparam int CH_N     = 5;
  localparam int ADDR_W   = 4;
  // byte address map
  localparam int A_CNT_HI = 0;
  localparam int A_CNT_LO = 1;
  localparam int A_CMP0   = 2;   // channel i high byte at A_CMP0+2i, low byte next
  localparam int A_MASK   = 12;
  localparam int A_FLAG   = 13;
endpackage

// File: rtl/ocu_counter.sv
module ocu_counter #(
  parameter int CNT_W  = 16,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              snap,
  output logic [CNT_W-1:0]  cnt_q,
  output logic [CNT_W-1:0]  cnt_nxt,
  output logic [BYTE_W-1:0] lo_hold
);
  assign cnt_nxt = cnt_q + CNT_W'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q   <= '0;
      lo_hold <= '0;
    end else begin
      if (tick) cnt_q <= cnt_nxt;
      if (snap) lo_hold <= cnt_q[BYTE_W-1:0];
    end
  end

  a_r1_advance: assert property (@(posedge clk) disable iff (rst)
    tick |=> cnt_q == $past(cnt_q) + CNT_W'(1));
  a_r1_hold: assert property (@(posedge clk) disable iff (rst)
    !tick |=> $stable(cnt_q));
  a_r2_capture: assert property (@(posedge clk) disable iff (rst)
    snap |=> lo_hold == $past(cnt_q[BYTE_W-1:0]));
  a_r2_keep: assert property (@(posedge clk) disable iff (rst)
    !snap |=> $stable(lo_hold));
endmodule

// File: rtl/ocu_channel.sv
module ocu_channel #(
  parameter int               CNT_W   = 16,
  parameter int               BYTE_W  = 8,
  parameter logic [CNT_W-1:0] RST_VAL = '1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_hi,
  input  logic              wr_lo,
  input  logic [BYTE_W-1:0] wdata,
  input  logic              tick,
  input  logic [CNT_W-1:0]  cnt_nxt,
  output logic [CNT_W-1:0]  cmp_q,
  output logic              hit
);
  localparam int HI_W = CNT_W - BYTE_W;

  logic [HI_W-1:0] hi_stage;

  always_ff @(posedge clk) begin
    if (rst) begin
      hi_stage <= RST_VAL[CNT_W-1:BYTE_W];
      cmp_q    <= RST_VAL;
    end else begin
      if (wr_hi) hi_stage <= wdata[HI_W-1:0];
      if (wr_lo) cmp_q    <= {hi_stage, wdata};
    end
  end

  // match when the coming tick lands the counter on the compare value
  assign hit = tick && (cnt_nxt == cmp_q);

  a_r3_staged: assert property (@(posedge clk) disable iff (rst)
    !wr_lo |=> $stable(cmp_q));
  a_r3_load: assert property (@(posedge clk) disable iff (rst)
    wr_lo |=> cmp_q[BYTE_W-1:0] == $past(wdata));
endmodule

// File: rtl/ocu_flags.sv
module ocu_flags #(
  parameter int REG_W = 8,
  parameter int CH_N  = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CH_N-1:0]  hit,
  input  logic             wr_mask,
  input  logic             wr_flag,
  input  logic [REG_W-1:0] wdata,
  output logic [REG_W-1:0] mask_q,
  output logic [REG_W-1:0] flag_q,
  output logic             irq_q
);
  logic [REG_W-1:0] set_vec;
  logic [REG_W-1:0] clr_vec;

  // channel 1 sits in the top bit, later channels below it
  always_comb begin
    set_vec = '0;
    for (int i = 0; i < CH_N; i++) set_vec[REG_W-1-i] = hit[i];
  end

  assign clr_vec = wr_flag ? wdata : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q <= '0;
      flag_q <= '0;
      irq_q  <= 1'b0;
    end else begin
      if (wr_mask) mask_q <= wdata;
      flag_q <= (flag_q & ~clr_vec) | set_vec;   // a match beats a clear
      irq_q  <= |(flag_q & mask_q);
    end
  end

  for (genvar g = 0; g < CH_N; g++) begin : g_chk
    a_r4_set: assert property (@(posedge clk) disable iff (rst)
      hit[g] |=> flag_q[REG_W-1-g]);
  end
  for (genvar b = 0; b < REG_W; b++) begin : g_keep
    a_r5_sticky: assert property (@(posedge clk) disable iff (rst)
      (flag_q[b] && !(wr_flag && wdata[b])) |=> flag_q[b]);
  end
  a_r8_raise: assert property (@(posedge clk) disable iff (rst)
    (|(flag_q & mask_q)) |=> irq_q);
  a_r8_drop: assert property (@(posedge clk) disable iff (rst)
    !(|(flag_q & mask_q)) |=> !irq_q);
endmodule

// File: rtl/ocu_timer.sv
module ocu_timer
  import ocu_pkg::*;
#(
  parameter int P_CNT_W  = CNT_W,
  parameter int P_BYTE_W = BYTE_W,
  parameter int P_CH_N   = CH_N,
  parameter int P_ADDR_W = ADDR_W
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                tick,
  input  logic                bus_sel,
  input  logic                bus_wr,
  input  logic [P_ADDR_W-1:0] bus_addr,
  input  logic [P_BYTE_W-1:0] bus_wdata,
  output logic [P_BYTE_W-1:0] bus_rdata,
  output logic                irq
);
  logic                rd_req, wr_req;
  logic [P_CNT_W-1:0]  cnt_q, cnt_nxt;
  logic [P_BYTE_W-1:0] lo_hold;
  logic [P_CNT_W-1:0]  cmp_arr [P_CH_N];
  logic [P_CH_N-1:0]   hit;
  logic [P_BYTE_W-1:0] mask_q, flag_q;
  logic [P_BYTE_W-1:0] rd_mux;
  int                  a_int;

  assign rd_req = bus_sel && !bus_wr;
  assign wr_req = bus_sel && bus_wr;
  assign a_int  = int'(bus_addr);

  ocu_counter #(.CNT_W(P_CNT_W), .BYTE_W(P_BYTE_W)) u_cnt (
    .clk(clk), .rst(rst), .tick(tick),
    .snap(rd_req && a_int == A_CNT_HI),
    .cnt_q(cnt_q), .cnt_nxt(cnt_nxt), .lo_hold(lo_hold)
  );

  for (genvar g = 0; g < P_CH_N; g++) begin : g_ch
    ocu_channel #(.CNT_W(P_CNT_W), .BYTE_W(P_BYTE_W)) u_ch (
      .clk(clk), .rst(rst),
      .wr_hi(wr_req && a_int == A_CMP0 + 2*g),
      .wr_lo(wr_req && a_int == A_CMP0 + 2*g + 1),
      .wdata(bus_wdata), .tick(tick), .cnt_nxt(cnt_nxt),
      .cmp_q(cmp_arr[g]), .hit(hit[g])
    );
  end

  ocu_flags #(.REG_W(P_BYTE_W), .CH_N(P_CH_N)) u_flags (
    .clk(clk), .rst(rst), .hit(hit),
    .wr_mask(wr_req && a_int == A_MASK),
    .wr_flag(wr_req && a_int == A_FLAG),
    .wdata(bus_wdata), .mask_q(mask_q), .flag_q(flag_q), .irq_q(irq)
  );

  always_comb begin
    rd_mux = '0;
    if (a_int == A_CNT_HI)      rd_mux = cnt_q[P_CNT_W-1 -: P_BYTE_W];
    else if (a_int == A_CNT_LO) rd_mux = lo_hold;
    else if (a_int == A_MASK)   rd_mux = mask_q;
    else if (a_int == A_FLAG)   rd_mux = flag_q;
    for (int i = 0; i < P_CH_N; i++) begin
      if (a_int == A_CMP0 + 2*i)     rd_mux = cmp_arr[i][P_CNT_W-1 -: P_BYTE_W];
      if (a_int == A_CMP0 + 2*i + 1) rd_mux = cmp_arr[i][P_BYTE_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst)         bus_rdata <= '0;
    else if (rd_req) bus_rdata <= rd_mux;
  end

  a_r11_hold: assert property (@(posedge clk) disable iff (rst)
    !rd_req |=> $stable(bus_rdata));
endmodule

// File: tb/ocu_timer_tb.sv
module ocu_timer_tb;
  logic       clk = 1'b0, rst = 1'b1, tick = 1'b0, sel = 1'b0, wr = 1'b0;
  logic [3:0] addr = '0;
  logic [7:0] wdata = '0;
  wire  [7:0] rdata;
  wire        irq;
  int n_chk = 0, n_bad = 0, exp_cnt = 0;
  bit done = 1'b0;
  logic [7:0] d;

  always #10 clk = ~clk;

  ocu_timer u_dut (
    .clk(clk), .rst(rst), .tick(tick), .bus_sel(sel), .bus_wr(wr),
    .bus_addr(addr), .bus_wdata(wdata), .bus_rdata(rdata), .irq(irq)
  );

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bwrite(logic [3:0] a, logic [7:0] v);
    sel = 1'b1; wr = 1'b1; addr = a; wdata = v;
    @(negedge clk);
    sel = 1'b0; wr = 1'b0;
  endtask

  task automatic bread(logic [3:0] a, output logic [7:0] v);
    sel = 1'b1; wr = 1'b0; addr = a;
    @(negedge clk);
    sel = 1'b0;
    v = rdata;
  endtask

  task automatic run_ticks(int n);
    tick = 1'b1;
    repeat (n) @(negedge clk);
    tick = 1'b0;
    exp_cnt = (exp_cnt + n) % 65536;
  endtask

  task automatic set_cmp(int ch, logic [15:0] v);
    bwrite(4'(2 + 2*ch), v[15:8]);
    bwrite(4'(3 + 2*ch), v[7:0]);
  endtask

  task automatic t_reset;
    bread(4'hC, d); chk("R10 mask", d, 8'h00);
    bread(4'hD, d); chk("R10 flag", d, 8'h00);
    bread(4'h2, d); chk("R10 cmp hi", d, 8'hFF);
    bread(4'hB, d); chk("R10 cmp lo", d, 8'hFF);
    chk("R10 irq", irq, 1'b0);
    bread(4'h0, d); chk("R1 reset hi", d, 8'h00);
    bread(4'h1, d); chk("R1 reset lo", d, 8'h00);
    bread(4'hE, d); chk("R11 unmapped", d, 8'h00);
    @(negedge clk); chk("R11 hold", rdata, 8'h00);
  endtask

  task automatic t_counter;
    run_ticks(300);
    bread(4'h0, d); chk("R1 count hi", d, 8'h01);
    run_ticks(5);
    bread(4'h1, d); chk("R2 captured lo", d, 8'h2C);
    bread(4'h0, d); chk("R1 count hi2", d, 8'h01);
    bread(4'h1, d); chk("R2 fresh lo", d, 8'h31);
  endtask

  task automatic t_stage;
    bwrite(4'h4, 8'h12);
    bread(4'h4, d); chk("R3 hi staged only", d, 8'hFF);
    bwrite(4'h5, 8'h34);
    bread(4'h4, d); chk("R3 hi loaded", d, 8'h12);
    bread(4'h5, d); chk("R3 lo loaded", d, 8'h34);
  endtask

  task automatic t_match;
    set_cmp(0, 16'd310);
    run_ticks(4);
    bread(4'hD, d); chk("R4 before match", d, 8'h00);
    run_ticks(1);
    bread(4'hD, d); chk("R4 ch1 match", d, 8'h80);
    repeat (2) @(negedge clk);
    chk("R7 polled irq low", irq, 1'b0);
  endtask

  task automatic t_clear;
    bwrite(4'hD, 8'h7F);
    bread(4'hD, d); chk("R5 zero keeps", d, 8'h80);
    bwrite(4'hD, 8'h80);
    bread(4'hD, d); chk("R5 one clears", d, 8'h00);
  endtask

  task automatic t_irq;
    set_cmp(2, 16'd312);
    bwrite(4'hC, 8'hA0);
    run_ticks(2);
    chk("R8 irq lag", irq, 1'b0);
    @(negedge clk);
    chk("R8 irq high", irq, 1'b1);
    bread(4'hD, d); chk("R9 ch3 bit5", d, 8'h20);
    bwrite(4'hD, 8'h20);
    repeat (2) @(negedge clk);
    chk("R8 irq low", irq, 1'b0);
    bwrite(4'hC, 8'h07);
    bread(4'hC, d); chk("R9 mask storage", d, 8'h07);
    bwrite(4'hD, 8'h07);
    bread(4'hD, d); chk("R9 ic flags zero", d, 8'h00);
    chk("R9 irq low", irq, 1'b0);
  endtask

  task automatic t_collide;
    set_cmp(3, 16'd314);
    run_ticks(1);
    tick = 1'b1; sel = 1'b1; wr = 1'b1; addr = 4'hD; wdata = 8'h10;
    @(negedge clk);
    tick = 1'b0; sel = 1'b0; wr = 1'b0;
    exp_cnt = (exp_cnt + 1) % 65536;
    bread(4'hD, d); chk("R6 set wins", d, 8'h10);
    bwrite(4'hD, 8'h10);
    bread(4'hD, d); chk("R5 cleared", d, 8'h00);
  endtask

  task automatic t_wrap;
    bwrite(4'hD, 8'hFF);
    run_ticks(65536);
    bread(4'hD, d); chk("R4 all after wrap", d, 8'hF8);
    bread(4'h0, d); chk("R1 wrap hi", d, 8'(exp_cnt >> 8));
    bread(4'h1, d); chk("R1 wrap lo", d, 8'(exp_cnt));
    chk("R7 masked irq low", irq, 1'b0);
    bwrite(4'hC, 8'h08);
    repeat (2) @(negedge clk);
    chk("R8 ch5 irq", irq, 1'b1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset;
    t_counter;
    t_stage;
    t_match;
    t_clear;
    t_irq;
    t_collide;
    t_wrap;
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule